// File: doc/BRIEF.md
# PWM Timer Channel

A single up-counting timer channel for producing waveforms. A counter advances once per prescaled event. The event comes from an external count source that is sampled on the system clock, and the counter can be cleared when it matches one of four compare registers. A pin controller drives one output. Its level at configuration time comes from a 3-bit pin code, and that code also sets what happens to the pin when the counter meets compare register A. In PWM mode the pin also returns to that starting level whenever the counter-clear match fires. Compare A then places the duty edge, and the clear register sets the period.

Software configures the channel through a plain register write port with a combinational read-back. It holds the `run_i` input low while it sets up the channel and raises it to let the counter advance. Two one-cycle pulses report matches on compare registers A and B.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset the counter and all registers read as zero and the pin is low.
- R2: Writing an address stores the value. Address 0 is control (8 bits), 1 is mode (2 bits), 2 is pin code (3 bits), 3 is the counter, and 4 to 7 are compare A, B, C and D. Reading an address returns the stored value, zero-extended. A counter write takes priority over counting.
- R3: The counter advances only while `run_i` is high. While `run_i` is low the counter and the pin hold their values, unless software writes them.
- R4: Control bits 4:3 select which count-source edge is counted: 0 counts rising edges, 1 falling edges, 2 or 3 both edges.
- R5: Control bits 1:0 set the prescale ratio. Codes 0, 1, 2 and 3 give one count per 1, 4, 16 and 64 selected edges.
- R6: Control bits 7:5 choose the clear source: 1 = A, 2 = B, 5 = C, 6 = D, and any other code means no clear. On a count where the counter equals the chosen register, the counter becomes 0. On any other count it increments and wraps from all-ones to 0.
- R7: A write of the pin code drives the pin to code bit 2 on the next cycle. On a count where the counter equals compare A, code bits 1:0 act on the pin: 0 holds, 1 drives low, 2 drives high, 3 toggles.
- R8: In PWM mode (mode bits 1:0 = 2), the pin returns to code bit 2 on a count that matches the clear source. With the clear on B, the pin sits at its starting level for counter values 0 to A and at the action level for counter values A+1 to B.
- R9: When the compare-A action and the PWM return fall on the same count, the return to the starting level wins.
- R10: A pin code whose action bits are 0 gives a constant pin level equal to code bit 2, which yields a fixed 0% or 100% output.
- R11: `hit_a_o` and `hit_b_o` each pulse for one cycle after a count on which the counter equalled compare A or compare B.
- R12: A compare register written while the channel runs is used from the next count onward, with no buffering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | CNT_W | Write data |
| rd_data_o | output | CNT_W | Read data for `addr_i`, combinational |
| run_i | input | 1 | Counter run enable |
| cnt_src_i | input | 1 | Count source level, synchronous to `clk` |
| pin_o | output | 1 | Waveform output |
| hit_a_o | output | 1 | Compare A match pulse |
| hit_b_o | output | 1 | Compare B match pulse |

## Verification
The following responses all land on the rising edge that follows the inputs causing them:
- a counter step, a counter clear, and a pin change all land on the clock edge where the prescaled count occurs;
- a pin-code write shows on the pin at the next edge;
- a match pulse appears one edge after the count that caused it.

Read data settles within the same cycle. The bench drives every input at the falling edge and samples 1 ns after the rising edge. It judges waveforms by counting high cycles, rising edges and match pulses over a window of exactly twelve periods, so the check does not depend on the phase at which the window starts. Directed checks of the counter use an exact number of run cycles, with one count per cycle.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;
   localparam int REG_ADDR_W = 3;

   localparam logic [2:0] RA_CTRL   = 3'd0;
   localparam logic [2:0] RA_MODE   = 3'd1;
   localparam logic [2:0] RA_PINCFG = 3'd2;
   localparam logic [2:0] RA_COUNT  = 3'd3;
   localparam logic [2:0] RA_CMP0   = 3'd4;

   localparam logic [2:0] CLR_ON_A = 3'd1;
   localparam logic [2:0] CLR_ON_B = 3'd2;
   localparam logic [2:0] CLR_ON_C = 3'd5;
   localparam logic [2:0] CLR_ON_D = 3'd6;

   localparam logic [1:0] EDGE_RISE = 2'd0;
   localparam logic [1:0] EDGE_FALL = 2'd1;

   localparam logic [1:0] MODE_PWM = 2'd2;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_LOW    = 2'd1,
      ACT_HIGH   = 2'd2,
      ACT_TOGGLE = 2'd3
   } pin_act_e;
endpackage

// File: rtl/pwmt_edge.sv
`timescale 1ns/1ps
module pwmt_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       src_i,
   input  logic [1:0] sel_i,
   output logic       evt_o
);
   import pwmt_pkg::*;

   logic src_s;
   logic src_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign src_s = src_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= src_i;
               for (int k = 1; k < SYNC_STAGES; k++) sh_q[k] <= sh_q[k-1];
            end
         end
         assign src_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= 1'b0;
      else        src_q <= src_s;
   end

   logic rise_w, fall_w;
   assign rise_w = src_s & ~src_q;
   assign fall_w = ~src_s & src_q;

   always_comb begin
      case (sel_i)
         EDGE_RISE: evt_o = rise_w;
         EDGE_FALL: evt_o = fall_w;
         default:   evt_o = rise_w | fall_w;
      endcase
   end
endmodule

// File: rtl/pwmt_prescale.sv
`timescale 1ns/1ps
module pwmt_prescale #(
   parameter  int NUM_DIV   = 4,
   parameter  int STEP_LOG2 = 2,
   localparam int SEL_W     = (NUM_DIV > 1) ? $clog2(NUM_DIV) : 1,
   localparam int PW        = STEP_LOG2 * (NUM_DIV - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic             evt_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   logic [PW-1:0] lim_tab [NUM_DIV];

   generate
      for (genvar g = 0; g < NUM_DIV; g++) begin : g_lim
         assign lim_tab[g] = {PW{1'b1}} >> (PW - STEP_LOG2 * g);
      end
   endgenerate

   logic [SEL_W-1:0] sel_eff;
   assign sel_eff = (int'(sel_i) < NUM_DIV) ? sel_i : SEL_W'(NUM_DIV - 1);

   logic [PW-1:0] pcnt_q;
   logic          at_lim;
   assign at_lim = (pcnt_q == lim_tab[sel_eff]);
   assign tick_o = run_i & evt_i & at_lim;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         pcnt_q <= '0;
      end else if (run_i && evt_i) begin
         pcnt_q <= at_lim ? '0 : pcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwmt_count.sv
`timescale 1ns/1ps
module pwmt_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [2:0]       clr_sel_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wr_val_i,
   input  logic [CNT_W-1:0] cmp_a_i,
   input  logic [CNT_W-1:0] cmp_b_i,
   input  logic [CNT_W-1:0] cmp_c_i,
   input  logic [CNT_W-1:0] cmp_d_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             a_hit_o,
   output logic             clr_hit_o,
   output logic             hit_a_o,
   output logic             hit_b_o
);
   import pwmt_pkg::*;

   logic [CNT_W-1:0] cnt_q;
   logic             clr_match;
   logic             eq_a, eq_b;

   assign eq_a = (cnt_q == cmp_a_i);
   assign eq_b = (cnt_q == cmp_b_i);

   always_comb begin
      case (clr_sel_i)
         CLR_ON_A: clr_match = eq_a;
         CLR_ON_B: clr_match = eq_b;
         CLR_ON_C: clr_match = (cnt_q == cmp_c_i);
         CLR_ON_D: clr_match = (cnt_q == cmp_d_i);
         default:  clr_match = 1'b0;
      endcase
   end

   assign a_hit_o   = tick_i & eq_a;
   assign clr_hit_o = tick_i & clr_match;
   assign cnt_o     = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         hit_a_o <= 1'b0;
         hit_b_o <= 1'b0;
      end else begin
         if (wr_i)           cnt_q <= wr_val_i;
         else if (clr_hit_o) cnt_q <= '0;
         else if (tick_i)    cnt_q <= cnt_q + 1'b1;
         hit_a_o <= a_hit_o;
         hit_b_o <= tick_i & eq_b;
      end
   end
endmodule

// File: rtl/pwmt_pin.sv
`timescale 1ns/1ps
module pwmt_pin (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_wr_i,
   input  logic       cfg_new_lvl_i,
   input  logic [2:0] cfg_i,
   input  logic       pwm_i,
   input  logic       a_hit_i,
   input  logic       clr_hit_i,
   output logic       pin_o
);
   import pwmt_pkg::*;

   logic     pin_q, pin_d;
   pin_act_e act;
   assign act = pin_act_e'(cfg_i[1:0]);

   always_comb begin
      pin_d = pin_q;
      if (cfg_wr_i) begin
         pin_d = cfg_new_lvl_i;
      end else if (pwm_i && clr_hit_i) begin
         pin_d = cfg_i[2];
      end else if (a_hit_i) begin
         case (act)
            ACT_LOW:    pin_d = 1'b0;
            ACT_HIGH:   pin_d = 1'b1;
            ACT_TOGGLE: pin_d = ~pin_q;
            default:    pin_d = pin_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_d;
   end

   assign pin_o = pin_q;
endmodule

// File: rtl/pwm_timer_chan.sv
`timescale 1ns/1ps
module pwm_timer_chan #(
   parameter int CNT_W       = 16,
   parameter int NUM_DIV     = 4,
   parameter int STEP_LOG2   = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [2:0]       addr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] rd_data_o,
   input  logic             run_i,
   input  logic             cnt_src_i,
   output logic             pin_o,
   output logic             hit_a_o,
   output logic             hit_b_o
);
   import pwmt_pkg::*;

   localparam int SEL_W   = (NUM_DIV > 1) ? $clog2(NUM_DIV) : 1;
   localparam int NUM_CMP = 4;

   generate
      if (CNT_W < 8) begin : g_bad_w
         $error("CNT_W must be at least 8");
      end
      if (NUM_DIV < 2 || SEL_W > 3) begin : g_bad_div
         $error("NUM_DIV must lie in 2..8");
      end
      if (STEP_LOG2 < 1) begin : g_bad_step
         $error("STEP_LOG2 must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [7:0]       ctrl_q;
   logic [1:0]       mode_q;
   logic [2:0]       pincfg_q;
   logic [CNT_W-1:0] cmp_q [NUM_CMP];

   logic ctrl_wr_w, cfg_wr_w, cnt_wr_w, pwm_w;
   assign ctrl_wr_w = wr_en_i && (addr_i == RA_CTRL);
   assign cfg_wr_w  = wr_en_i && (addr_i == RA_PINCFG);
   assign cnt_wr_w  = wr_en_i && (addr_i == RA_COUNT);
   assign pwm_w     = (mode_q == MODE_PWM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         mode_q   <= '0;
         pincfg_q <= '0;
      end else if (wr_en_i) begin
         case (addr_i)
            RA_CTRL:   ctrl_q   <= wr_data_i[7:0];
            RA_MODE:   mode_q   <= wr_data_i[1:0];
            RA_PINCFG: pincfg_q <= wr_data_i[2:0];
            default: ;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n) cmp_q[g] <= '0;
            else if (wr_en_i && (addr_i == 3'(int'(RA_CMP0) + g)))
               cmp_q[g] <= wr_data_i;
         end
      end
   endgenerate

   logic             evt_w, tick_w, a_hit_w, clr_hit_w;
   logic [CNT_W-1:0] cnt_w;

   pwmt_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .src_i (cnt_src_i),
      .sel_i (ctrl_q[4:3]),
      .evt_o (evt_w)
   );

   pwmt_prescale #(.NUM_DIV(NUM_DIV), .STEP_LOG2(STEP_LOG2)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (ctrl_wr_w),
      .run_i  (run_i),
      .evt_i  (evt_w),
      .sel_i  (ctrl_q[SEL_W-1:0]),
      .tick_o (tick_w)
   );

   pwmt_count #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_w),
      .clr_sel_i (ctrl_q[7:5]),
      .wr_i      (cnt_wr_w),
      .wr_val_i  (wr_data_i),
      .cmp_a_i   (cmp_q[0]),
      .cmp_b_i   (cmp_q[1]),
      .cmp_c_i   (cmp_q[2]),
      .cmp_d_i   (cmp_q[3]),
      .cnt_o     (cnt_w),
      .a_hit_o   (a_hit_w),
      .clr_hit_o (clr_hit_w),
      .hit_a_o   (hit_a_o),
      .hit_b_o   (hit_b_o)
   );

   pwmt_pin u_pin (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_wr_i      (cfg_wr_w),
      .cfg_new_lvl_i (wr_data_i[2]),
      .cfg_i         (pincfg_q),
      .pwm_i         (pwm_w),
      .a_hit_i       (a_hit_w),
      .clr_hit_i     (clr_hit_w),
      .pin_o         (pin_o)
   );

   always_comb begin
      case (addr_i)
         RA_CTRL:   rd_data_o = CNT_W'(ctrl_q);
         RA_MODE:   rd_data_o = CNT_W'(mode_q);
         RA_PINCFG: rd_data_o = CNT_W'(pincfg_q);
         RA_COUNT:  rd_data_o = cnt_w;
         default:   rd_data_o = cmp_q[addr_i[1:0]];
      endcase
   end
endmodule

// File: rtl/pwm_timer_chan_chk.sv
`timescale 1ns/1ps
module pwm_timer_chan_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [CNT_W-1:0] cnt,
   input logic             tick,
   input logic             clr_hit,
   input logic             a_hit,
   input logic             cnt_wr,
   input logic             cfg_wr,
   input logic             cfg_new_lvl,
   input logic             init_lvl,
   input logic             pwm,
   input logic             pin,
   input logic             hit_a
);
   AST_STOP_HOLD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt));                           // R3
   AST_STOP_HOLD_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cfg_wr) |=> $stable(pin));                           // R3
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !cnt_wr) |=> (cnt == '0));                         // R6
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr_hit && !cnt_wr) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R6
   AST_CFG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (pin == $past(cfg_new_lvl)));                       // R7
   AST_PWM_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm && clr_hit && !cfg_wr) |=> (pin == $past(init_lvl)));     // R9
   AST_HIT_A_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_a |-> $past(a_hit));                                       // R11
endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run         (run_i),
   .cnt         (cnt_w),
   .tick        (tick_w),
   .clr_hit     (clr_hit_w),
   .a_hit       (a_hit_w),
   .cnt_wr      (cnt_wr_w),
   .cfg_wr      (cfg_wr_w),
   .cfg_new_lvl (wr_data_i[2]),
   .init_lvl    (pincfg_q[2]),
   .pwm         (pwm_w),
   .pin         (pin_o),
   .hit_a       (hit_a_o)
);

// File: tb/pwm_timer_chan_bench.sv
`timescale 1ns/1ps
module pwm_timer_chan_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;
   logic        run = 1'b0;
   logic        src = 1'b0;
   logic        pin, hit_a, hit_b;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #10 clk = ~clk;

   // count source toggles once per cycle
   always @(negedge clk) src <= ~src;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   pwm_timer_chan u_pwm_timer_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .addr_i    (addr),
      .wr_data_i (wdata),
      .rd_data_o (rdata),
      .run_i     (run),
      .cnt_src_i (src),
      .pin_o     (pin),
      .hit_a_o   (hit_a),
      .hit_b_o   (hit_b)
   );

   typedef struct packed {
      logic [1:0]  edg;
      logic [1:0]  psc;
      logic [15:0] ca;
      logic [15:0] cb;
      logic [2:0]  io;
      logic [31:0] hi;
   } vec_t;

   // PWM with clear on B; expected high cycles over twelve periods
   localparam vec_t VECS [9] = '{
      '{2'd2, 2'd0, 16'd2, 16'd5, 3'd2, 32'd36},
      '{2'd2, 2'd0, 16'd0, 16'd3, 3'd2, 32'd36},
      '{2'd2, 2'd1, 16'd1, 16'd3, 3'd2, 32'd96},
      '{2'd2, 2'd0, 16'd4, 16'd9, 3'd5, 32'd60},
      '{2'd2, 2'd0, 16'd1, 16'd2, 3'd3, 32'd12},
      '{2'd2, 2'd2, 16'd0, 16'd1, 3'd2, 32'd192},
      '{2'd0, 2'd0, 16'd2, 16'd5, 3'd2, 32'd72},
      '{2'd1, 2'd0, 16'd2, 16'd5, 3'd2, 32'd72},
      '{2'd2, 2'd3, 16'd0, 16'd1, 3'd2, 32'd768}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int d);
      @(negedge clk);
      addr = a;
      #1 d = int'(rdata);
   endtask

   task automatic setup(input logic [2:0] clr, input logic [1:0] edg,
                        input logic [1:0] psc, input logic [1:0] mode,
                        input logic [15:0] ca, input logic [15:0] cb,
                        input logic [2:0] io);
      @(negedge clk) run = 1'b0;
      wr(3'd0, {8'd0, clr, edg, 1'b0, psc});
      wr(3'd1, {14'd0, mode});
      wr(3'd4, ca);
      wr(3'd5, cb);
      wr(3'd3, 16'd0);
      wr(3'd2, {13'd0, io});
   endtask

   task automatic measure(input int n, output int hi, output int rises, output int hits);
      logic prev;
      hi = 0; rises = 0; hits = 0;
      @(posedge clk); #1 prev = pin;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         if (pin) hi++;
         if (pin && !prev) rises++;
         if (hit_a) hits++;
         prev = pin;
      end
   endtask

   initial begin
      int d, d2, hi, rs, hs, win;
      logic p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R1: reset state
      chk("R1 pin", int'(pin), 0);
      rd(3'd0, d); chk("R1 ctrl", d, 0);
      rd(3'd3, d); chk("R1 counter", d, 0);
      rd(3'd5, d); chk("R1 cmpB", d, 0);

      // R2: write and readback
      wr(3'd4, 16'h1234); rd(3'd4, d); chk("R2 cmpA", d, 16'h1234);
      wr(3'd7, 16'hBEEF); rd(3'd7, d); chk("R2 cmpD", d, 16'hBEEF);
      wr(3'd3, 16'h00AB); rd(3'd3, d); chk("R2 counter", d, 16'h00AB);
      wr(3'd2, 16'hFFFD); rd(3'd2, d); chk("R2 pincfg", d, 5);

      // table of PWM waveforms (R4 edges, R5 prescale, R7/R8 shapes, R11 pulses)
      for (int v = 0; v < 9; v++) begin
         string tag;
         int div, ef;
         div = 1 << (2 * int'(VECS[v].psc));
         ef  = (VECS[v].edg == 2'd2) ? 1 : 2;
         win = 12 * (int'(VECS[v].cb) + 1) * div * ef;
         if (VECS[v].edg != 2'd2)          tag = "R4 edge";
         else if (VECS[v].psc != 2'd0)     tag = "R5 prescale";
         else if (VECS[v].io[1:0] == 2'd3) tag = "R7 toggle";
         else                              tag = "R8 pwm";
         setup(3'd2, VECS[v].edg, VECS[v].psc, 2'd2, VECS[v].ca, VECS[v].cb, VECS[v].io);
         @(negedge clk) run = 1'b1;
         repeat (win / 12 + 2) @(posedge clk);
         measure(win, hi, rs, hs);
         chk({tag, " high"}, hi, int'(VECS[v].hi));
         chk({tag, " rises"}, rs, 12);
         chk("R11 hit_a count", hs, 12);
      end

      // R12: change duty while running
      setup(3'd2, 2'd2, 2'd0, 2'd2, 16'd2, 16'd5, 3'd2);
      @(negedge clk) run = 1'b1;
      repeat (12) @(posedge clk);
      wr(3'd4, 16'd4);
      repeat (12) @(posedge clk);
      measure(72, hi, rs, hs);
      chk("R12 new duty high", hi, 12);

      // R3: stop holds counter and pin
      @(negedge clk) run = 1'b0;
      #1 p0 = pin;
      rd(3'd3, d);
      repeat (20) @(posedge clk);
      rd(3'd3, d2);
      chk("R3 counter held", d2, d);
      chk("R3 pin held", int'(pin), int'(p0));

      // R9: A equals B, return wins
      setup(3'd2, 2'd2, 2'd0, 2'd2, 16'd3, 16'd3, 3'd2);
      @(negedge clk) run = 1'b1;
      measure(48, hi, rs, hs);
      chk("R9 same-count high", hi, 0);

      // R10: fixed levels
      setup(3'd2, 2'd2, 2'd0, 2'd2, 16'd2, 16'd5, 3'd4);
      @(negedge clk) run = 1'b1;
      measure(50, hi, rs, hs);
      chk("R10 fixed high", hi, 50);
      setup(3'd2, 2'd2, 2'd0, 2'd2, 16'd2, 16'd5, 3'd0);
      @(negedge clk) run = 1'b1;
      measure(50, hi, rs, hs);
      chk("R10 fixed low", hi, 0);

      // R7 normal mode, clear on A, toggle
      setup(3'd1, 2'd2, 2'd0, 2'd0, 16'd3, 16'd0, 3'd3);
      @(negedge clk) run = 1'b1;
      repeat (10) @(posedge clk);
      measure(80, hi, rs, hs);
      chk("R7 toggle high", hi, 40);
      chk("R7 toggle rises", rs, 10);

      // R6 clear on C and on D
      setup(3'd5, 2'd2, 2'd0, 2'd2, 16'd1, 16'd0, 3'd2);
      wr(3'd6, 16'd4);
      @(negedge clk) run = 1'b1;
      repeat (10) @(posedge clk);
      measure(60, hi, rs, hs);
      chk("R6 clear-C high", hi, 36);
      setup(3'd6, 2'd2, 2'd0, 2'd2, 16'd1, 16'd0, 3'd2);
      wr(3'd7, 16'd6);
      @(negedge clk) run = 1'b1;
      repeat (10) @(posedge clk);
      measure(70, hi, rs, hs);
      chk("R6 clear-D high", hi, 50);

      // R3 exact counting, R6 wrap with no clear
      setup(3'd0, 2'd2, 2'd0, 2'd0, 16'd0, 16'd0, 3'd0);
      @(negedge clk) run = 1'b1;
      repeat (10) @(negedge clk);
      run = 1'b0;
      rd(3'd3, d); chk("R3 ten counts", d, 10);
      wr(3'd3, 16'hFFFE);
      @(negedge clk) run = 1'b1;
      repeat (3) @(negedge clk);
      run = 1'b0;
      rd(3'd3, d); chk("R6 wrap", d, 1);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule